// File: doc/BRIEF.md
# Hardware-Sequenced SPI Flash Read Controller

This block runs a complete serial-flash read on its own, so the host needs no knowledge of the flash command set. The host programs a flash byte address and a control word that holds a byte count and a cycle type, and sets a start bit in that control word. The controller then drives a single-bit SPI master. It asserts chip select, shifts out the read opcode and a 24-bit address, and clocks in between 1 and 64 bytes. The bytes land in a 16-word data window.

Progress and outcome appear in a status word. A busy flag is set for the whole transaction. A done flag, an access-error flag and a collision flag are sticky, and the host clears each by writing one to its bit. Only the read cycle type runs. Write and erase types are decoded and rejected, and so is an address outside the configured flash size. The host side is a plain 32-bit register bus with single-cycle writes and a combinational read.

Top module: `hwseq_flash_ctrl`

## Requirements
- R1: After reset, every register reads zero, chip select is high (`spi_cs_n`=1) and the SPI clock is low.
- R2: An accepted read holds chip select low for the whole frame. The frame shifts out opcode 0x03 and then the 24-bit address, most significant bit first, in SPI mode 0: the clock idles low, MOSI changes only on falling edges and MISO is sampled on rising edges. The frame has exactly 32 + 8*count clock pulses.
- R3: Status bit 5 (busy) reads 1 from the clock edge that accepts the start until exactly (32 + 8*count) * SCK_DIV cycles later. Status bit 0 (done) becomes 1 in the same cycle that busy clears.
- R4: The control word at offset 0x04 holds count-1 in bits 13:8. Received byte k goes to data word k/4, at offset 0x40 + 4*(k/4), in byte lane k%4, so flash byte 0 is the least significant byte of word 0. Bytes beyond the count keep their previous contents.
- R5: A start (control bit 0) with cycle type bits 2:1 not equal to 0 sets the access-error flag (status bit 2) and the done flag. It does not set busy and does not toggle chip select. The value 0 selects read, 2 selects write and 3 selects erase.
- R6: A start while the address register (offset 0x08) is at or above FLASH_BYTES sets the access-error flag and the done flag, and it does not toggle chip select.
- R7: A start while busy is 1 sets the collision flag (status bit 1) and is otherwise ignored. The running frame completes with its original count, and writes to the control and address registers have no effect while busy.
- R8: Writing one to status bits 0, 1 or 2 clears that flag. Writing zero leaves a flag as it is. Busy cannot be changed by a status write.
- R9: The control word reads back its count field and its type field. The start bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset (status 0x00, control 0x04, address 0x08, data 0x40-0x7C) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Reads are run with a full 64-byte count, with 13 and 5 bytes (which end in the middle of a word), and with a single byte at the last valid address. These show whether packing is correct lane by lane, whether the partial final word keeps its untouched lanes, and whether the frame length tracks the count field. A behavioural flash model returns address-dependent bytes and records the opcode and address it receives. Each clock, a cycle model compares chip select, the SPI clock and the busy bit. Starts with each non-read type, with an out-of-range address and during a running frame confirm that rejection and collision leave both the pins and the buffer alone.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    // Register word indices (byte offset / 4)
    localparam int WORD_STATUS = 0;
    localparam int WORD_CTRL   = 1;
    localparam int WORD_ADDR   = 2;
    localparam int WORD_DATA0  = 16;

    // Status bit positions
    localparam int ST_DONE  = 0;
    localparam int ST_FCERR = 1;
    localparam int ST_AEL   = 2;
    localparam int ST_BUSY  = 5;

    // Control field positions
    localparam int CT_GO      = 0;
    localparam int CT_KIND_LO = 1;
    localparam int CT_CNT_LO  = 8;
    localparam int CNT_W      = 6;

    // Buffer geometry
    localparam int MAX_BYTES = 1 << CNT_W;
    localparam int NUM_WORDS = MAX_BYTES / 4;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int FLASH_AW  = 24;
    localparam int HDR_BITS  = 8 + FLASH_AW;
    localparam int FRAME_W   = $clog2(HDR_BITS + 8 * MAX_BYTES) + 1;

    localparam logic [7:0] OPC_READ = 8'h03;

    typedef enum logic [1:0] {
        CYC_READ  = 2'd0,
        CYC_RSVD  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_ERASE = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt_m1;
        cyc_kind_e        kind;
    } ctrl_s;

    typedef struct packed {
        logic busy;
        logic ael;
        logic fcerr;
        logic done;
    } flags_s;

    typedef struct packed {
        logic [FLASH_AW-1:0] addr;
        logic [CNT_W:0]      nbytes;
    } job_s;

    function automatic logic [CNT_W:0] field_to_bytes(input logic [CNT_W-1:0] f);
        return {1'b0, f} + 1'b1;
    endfunction

    function automatic logic [FRAME_W-1:0] frame_bits(input logic [CNT_W:0] n);
        return FRAME_W'(HDR_BITS) + FRAME_W'({n, 3'b000});
    endfunction

    function automatic logic [31:0] pack_status(input flags_s f);
        logic [31:0] s;
        s = '0;
        s[ST_BUSY]  = f.busy;
        s[ST_AEL]   = f.ael;
        s[ST_FCERR] = f.fcerr;
        s[ST_DONE]  = f.done;
        return s;
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_s c);
        logic [31:0] v;
        v = '0;
        v[CT_CNT_LO +: CNT_W] = c.cnt_m1;
        v[CT_KIND_LO +: 2]    = c.kind;
        return v;
    endfunction

endpackage

// File: rtl/hsf_tick.sv
module hsf_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hsf_seq.sv
module hsf_seq
    import hsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  job_s             job,
    input  logic             tick,
    input  logic             miso,
    output logic             run,
    output logic             fin,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_idx,
    output logic [7:0]       buf_byte
);
    typedef enum logic {SEQ_IDLE, SEQ_SHIFT} seq_state_e;

    seq_state_e         state_q;
    logic               sck_q;
    logic               cs_q;
    logic [31:0]        out_sr;
    logic [FRAME_W-1:0] bit_q;
    logic [FRAME_W-1:0] last_q;
    logic [7:0]         in_sr;
    logic               we_q;
    logic [IDX_W-1:0]   idx_q;
    logic [7:0]         byte_q;
    logic [FRAME_W-1:0] dbit;
    logic               in_data;
    logic               unused_seq;

    assign dbit       = bit_q - FRAME_W'(HDR_BITS);
    assign in_data    = bit_q >= FRAME_W'(HDR_BITS);
    assign run        = (state_q == SEQ_SHIFT);
    assign fin        = run && tick && sck_q && (bit_q == last_q);
    assign sck        = sck_q;
    assign cs_n       = cs_q;
    assign mosi       = out_sr[31];
    assign buf_we     = we_q;
    assign buf_idx    = idx_q;
    assign buf_byte   = byte_q;
    assign unused_seq = ^dbit[FRAME_W-1:IDX_W+3];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            out_sr  <= '0;
            bit_q   <= '0;
            last_q  <= '0;
            in_sr   <= '0;
            we_q    <= 1'b0;
            idx_q   <= '0;
            byte_q  <= '0;
        end else begin
            we_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_SHIFT;
                        cs_q    <= 1'b0;
                        sck_q   <= 1'b0;
                        out_sr  <= {OPC_READ, job.addr};
                        bit_q   <= '0;
                        last_q  <= frame_bits(job.nbytes) - 1'b1;
                    end
                end
                default: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                            if (in_data) begin
                                in_sr <= {in_sr[6:0], miso};
                                if (bit_q[2:0] == 3'd7) begin
                                    we_q   <= 1'b1;
                                    byte_q <= {in_sr[6:0], miso};
                                    idx_q  <= dbit[IDX_W+2:3];
                                end
                            end
                        end else begin
                            sck_q <= 1'b0;
                            if (bit_q == last_q) begin
                                state_q <= SEQ_IDLE;
                                cs_q    <= 1'b1;
                            end else begin
                                bit_q  <= bit_q + 1'b1;
                                out_sr <= {out_sr[30:0], 1'b0};
                            end
                        end
                    end
                end
            endcase
        end
    end

    // R2
    clock_framed_chk: assert property (@(posedge clk) disable iff (rst)
        sck_q |-> !cs_q);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sck_q && $past(sck_q)) |-> $stable(out_sr[31]));
endmodule

// File: rtl/hsf_regs.sv
module hsf_regs
    import hsf_pkg::*;
#(
    parameter int FLASH_BYTES = 1 << 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             fin,
    input  logic             buf_we,
    input  logic [IDX_W-1:0] buf_idx,
    input  logic [7:0]       buf_byte,
    output logic             start,
    output job_s             job
);
    ctrl_s       ctrl_q;
    logic [31:0] faddr_q;
    flags_s      flags_q;
    logic [7:0]  lane_q [MAX_BYTES];

    logic [5:0]  word;
    logic        wr_status, wr_ctrl, wr_addr;
    logic        go_req, bad, reject, collide;
    cyc_kind_e   new_kind;
    logic        unused_bits;

    assign word      = reg_addr[7:2];
    assign wr_status = reg_wr && (word == 6'(WORD_STATUS));
    assign wr_ctrl   = reg_wr && (word == 6'(WORD_CTRL));
    assign wr_addr   = reg_wr && (word == 6'(WORD_ADDR));
    assign new_kind  = cyc_kind_e'(reg_wdata[CT_KIND_LO +: 2]);
    assign go_req    = wr_ctrl && reg_wdata[CT_GO];
    assign bad       = (new_kind != CYC_READ) || (faddr_q >= 32'(FLASH_BYTES));
    assign collide   = go_req && flags_q.busy;
    assign reject    = go_req && !flags_q.busy && bad;
    assign start     = go_req && !flags_q.busy && !bad;

    assign job.addr   = faddr_q[FLASH_AW-1:0];
    assign job.nbytes = field_to_bytes(reg_wdata[CT_CNT_LO +: CNT_W]);

    assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:CT_CNT_LO+CNT_W],
                           reg_wdata[CT_CNT_LO-1:CT_KIND_LO+2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{cnt_m1: '0, kind: CYC_READ};
            faddr_q <= '0;
            flags_q <= '0;
        end else begin
            if (wr_ctrl && !flags_q.busy) begin
                ctrl_q.cnt_m1 <= reg_wdata[CT_CNT_LO +: CNT_W];
                ctrl_q.kind   <= new_kind;
            end
            if (wr_addr && !flags_q.busy) begin
                faddr_q <= reg_wdata;
            end
            if (start) begin
                flags_q.busy <= 1'b1;
            end else if (fin) begin
                flags_q.busy <= 1'b0;
            end
            if (fin || reject) begin
                flags_q.done <= 1'b1;
            end else if (wr_status && reg_wdata[ST_DONE]) begin
                flags_q.done <= 1'b0;
            end
            if (reject) begin
                flags_q.ael <= 1'b1;
            end else if (wr_status && reg_wdata[ST_AEL]) begin
                flags_q.ael <= 1'b0;
            end
            if (collide) begin
                flags_q.fcerr <= 1'b1;
            end else if (wr_status && reg_wdata[ST_FCERR]) begin
                flags_q.fcerr <= 1'b0;
            end
        end
    end

    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[k] <= '0;
            end else if (buf_we && (buf_idx == IDX_W'(k))) begin
                lane_q[k] <= buf_byte;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (word == 6'(WORD_STATUS)) begin
            reg_rdata = pack_status(flags_q);
        end else if (word == 6'(WORD_CTRL)) begin
            reg_rdata = pack_ctrl(ctrl_q);
        end else if (word == 6'(WORD_ADDR)) begin
            reg_rdata = faddr_q;
        end else if (word >= 6'(WORD_DATA0) && word < 6'(WORD_DATA0 + NUM_WORDS)) begin
            for (int b = 0; b < 4; b++) begin
                reg_rdata[8*b +: 8] = lane_q[{word[3:0], 2'(b)}];
            end
        end
    end

    // R3
    done_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_q.busy) |-> flags_q.done);

    // R7
    go_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        collide |=> flags_q.fcerr);

    // R5
    reject_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (go_req && !flags_q.busy && new_kind != CYC_READ) |=> (flags_q.ael && flags_q.done && !flags_q.busy));

    // R6
    reject_range_chk: assert property (@(posedge clk) disable iff (rst)
        (go_req && !flags_q.busy && faddr_q >= 32'(FLASH_BYTES)) |=> (flags_q.ael && !flags_q.busy));

    // R8
    busy_not_writable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_status && !flags_q.busy) |=> !flags_q.busy);
endmodule

// File: rtl/hwseq_flash_ctrl.sv
module hwseq_flash_ctrl
    import hsf_pkg::*;
#(
    parameter int SCK_DIV     = 4,
    parameter int FLASH_BYTES = 1 << 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int HALF = (SCK_DIV / 2 < 1) ? 1 : SCK_DIV / 2;

    logic             start, fin, run, tick;
    job_s             job;
    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;
    logic [7:0]       buf_byte;

    hsf_regs #(.FLASH_BYTES(FLASH_BYTES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .fin      (fin),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .buf_byte (buf_byte),
        .start    (start),
        .job      (job)
    );

    hsf_tick #(.HALF(HALF)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tick(tick)
    );

    hsf_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .job     (job),
        .tick    (tick),
        .miso    (spi_miso),
        .run     (run),
        .fin     (fin),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .buf_we  (buf_we),
        .buf_idx (buf_idx),
        .buf_byte(buf_byte)
    );
endmodule

// File: tb/hwseq_flash_ctrl_test.sv
module hwseq_flash_ctrl_test;
    localparam int DIV    = 4;
    localparam int FBYTES = 1 << 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    always #4 clk = ~clk;

    hwseq_flash_ctrl #(.SCK_DIV(DIV), .FLASH_BYTES(FBYTES)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int          checks = 0;
    int          fails = 0;
    int          left = 0;
    int          cs_falls = 0;
    int          s_bits = 0;
    logic [31:0] s_cmd = 0;
    logic [31:0] exp_w [16];
    logic [7:0]  s_byte;
    int          s_d;

    function automatic logic [7:0] fbyte(input int a);
        return 8'(a * 37) ^ 8'(a >> 8) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural flash slave
    always @(negedge spi_cs_n) begin
        cs_falls++;
        s_bits = 0;
        s_cmd = 0;
        chk(spi_sck == 1'b0, "R2 clock low at select", 32'(spi_sck), 0);
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (s_bits < 32) s_cmd = {s_cmd[30:0], spi_mosi};
            s_bits++;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && s_bits >= 32) begin
            s_d = s_bits - 32;
            s_byte = fbyte(int'(s_cmd[23:0]) + s_d / 8);
            spi_miso <= s_byte[7 - (s_d % 8)];
        end
    end

    // Cycle model comparison on every clock
    always @(negedge clk) begin
        if (!rst) begin
            #2;
            chk(spi_cs_n == (left == 0), "R2 select framing", 32'(spi_cs_n), 32'(left == 0));
            if (left == 0) chk(spi_sck == 1'b0, "R2 clock idle", 32'(spi_sck), 0);
            if (!reg_wr && reg_addr == 8'h00)
                chk(reg_rdata[5] == (left > 0), "R3 busy flag", 32'(reg_rdata[5]), 32'(left > 0));
            if (left > 0) left--;
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 32'h0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 8'h00;
    endtask

    task automatic check_buffer(input string tag);
        logic [31:0] v;
        for (int w = 0; w < 16; w++) begin
            bus_read(8'(8'h40 + 4 * w), v);
            chk(v == exp_w[w], tag, v, exp_w[w]);
        end
    endtask

    task automatic start_read(input int a, input int n);
        bus_write(8'h00, 32'h7);
        bus_write(8'h08, 32'(a));
        bus_write(8'h04, (32'(n - 1) << 8) | 32'h1);
        left = (32 + 8 * n) * DIV;
        for (int k = 0; k < n; k++) exp_w[k / 4][8 * (k % 4) +: 8] = fbyte(a + k);
    endtask

    task automatic finish_read(input int a, input int n, input logic [31:0] st, input string tag);
        logic [31:0] v;
        while (left > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        bus_read(8'h00, v);
        chk(v == st, {tag, " R3 status after frame"}, v, st);
        chk(s_cmd == {8'h03, 24'(a)}, {tag, " R2 opcode and address"}, s_cmd, {8'h03, 24'(a)});
        chk(s_bits == 32 + 8 * n, {tag, " R2 clock pulses"}, 32'(s_bits), 32'(32 + 8 * n));
        check_buffer({tag, " R4 data window"});
    endtask

    task automatic reject_case(input logic [31:0] a, input logic [1:0] kind, input string tag);
        logic [31:0] v;
        int cf;
        bus_write(8'h00, 32'h7);
        bus_write(8'h08, a);
        cf = cs_falls;
        bus_write(8'h04, 32'h0300 | (32'(kind) << 1) | 32'h1);
        repeat (6) @(negedge clk);
        bus_read(8'h00, v);
        chk(v == 32'h5, {tag, " status"}, v, 32'h5);
        chk(cs_falls == cf, {tag, " select untouched"}, 32'(cs_falls), 32'(cf));
        check_buffer({tag, " buffer untouched"});
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        int cf;
        for (int w = 0; w < 16; w++) exp_w[w] = 32'h0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 select high", 32'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R1 clock low", 32'(spi_sck), 0);
        bus_read(8'h00, v); chk(v == 0, "R1 status", v, 0);
        bus_read(8'h04, v); chk(v == 0, "R1 control", v, 0);
        bus_read(8'h08, v); chk(v == 0, "R1 address", v, 0);
        check_buffer("R1 data zero");

        // Full, partial and single-byte reads (R2 R3 R4)
        start_read(32'h0E0000, 64); finish_read(32'h0E0000, 64, 32'h1, "full64");
        start_read(32'h0ABCDE, 13); finish_read(32'h0ABCDE, 13, 32'h1, "len13");
        start_read(32'h000123, 5);  finish_read(32'h000123, 5, 32'h1, "len5");
        start_read(FBYTES - 1, 1);  finish_read(FBYTES - 1, 1, 32'h1, "last1");

        // R9 control readback, start bit reads 0
        bus_write(8'h04, 32'h2A06);
        bus_read(8'h04, v); chk(v == 32'h2A06, "R9 control readback", v, 32'h2A06);

        // R5 non-read types rejected
        reject_case(32'h100, 2'd2, "R5 write type");
        reject_case(32'h100, 2'd3, "R5 erase type");
        reject_case(32'h100, 2'd1, "R5 reserved type");
        // R6 address out of range
        reject_case(32'(FBYTES), 2'd0, "R6 out of range");

        // R8 write-one-to-clear
        bus_write(8'h00, 32'h0);
        bus_read(8'h00, v); chk(v == 32'h5, "R8 zero write keeps flags", v, 32'h5);
        bus_write(8'h00, 32'h4);
        bus_read(8'h00, v); chk(v == 32'h1, "R8 clear access error", v, 32'h1);
        bus_write(8'h00, 32'h1);
        bus_read(8'h00, v); chk(v == 32'h0, "R8 clear done", v, 32'h0);
        bus_write(8'h00, 32'h20);
        bus_read(8'h00, v); chk(v == 32'h0, "R8 busy not writable", v, 32'h0);

        // R7 start while busy
        start_read(32'h000040, 8);
        repeat (20) @(negedge clk);
        cf = cs_falls;
        bus_write(8'h08, 32'h00FFFF);
        bus_write(8'h04, 32'h0F07);
        bus_read(8'h04, v); chk(v == 32'h0700, "R7 control held while busy", v, 32'h0700);
        bus_read(8'h08, v); chk(v == 32'h40, "R7 address held while busy", v, 32'h40);
        chk(cs_falls == cf, "R7 frame not restarted", 32'(cs_falls), 32'(cf));
        finish_read(32'h000040, 8, 32'h3, "R7 collision");

        summary();
    end
endmodule